// File: doc/BRIEF.md
# Five-Channel Voltage Conversion Sequencer with Sample Averaging

The block schedules conversions on an external analog-to-digital converter for five supply-monitoring channels and keeps one result register per channel. Normally it walks the channels in a fixed round-robin order. For each visit it takes sixteen back-to-back conversions of one channel, sums them in a widened accumulator and publishes the sum divided by sixteen. The value register changes only once all sixteen samples have arrived. A configuration bit turns averaging off. Each conversion is then published on its own, so results refresh sixteen times as often, though with more noise.

A second configuration bit locks the sequencer onto one channel, which is converted over and over while the others are left alone. The locked channel comes from a three-bit field at bits 7:5 of a separate select register. Codes 5 to 7 are reserved: they stop all conversions and the stored results are held. A third configuration bit, the attenuator-bypass flag, is only stored and read back. Any write that changes the averaging bit, the lock bit or the channel field abandons the conversion in progress and restarts sequencing.

The converter handshake is a one-cycle start pulse with a channel number. The converter answers with a done pulse that carries a 10-bit sample. A programmable idle gap between conversions sets the overall refresh rate: with the internal timebase, a full averaged update of every channel takes about 711 ms. A read port also mirrors five identification input pins.

Top module: `volt_scan_ctrl`

## Requirements
- R1: After reset, every register reads zero: the configuration register (address 0), the select register (address 1) and the five result registers (addresses 2 to 6, channel 0 to 4). Also `adc_start` stays low for at least GAP_CYCLES cycles after reset is released.
- R2: With the lock bit (configuration bit 6) clear, conversions visit the channels in the order 0,1,2,3,4,0 and so on, starting at channel 0 after a restart. `adc_chan` is never above 4 while `adc_start` is high.
- R3: With the averaging-off bit (configuration bit 4) clear, a channel's result register keeps its old value through the first fifteen samples of a visit. After the sixteenth sample it becomes the floor of the sum of those sixteen samples divided by 16.
- R4: With configuration bit 4 set, each done pulse writes its sample unchanged into the result register of the converted channel.
- R5: With configuration bit 6 set, only the channel coded in select-register bits 7:5 is converted (0 = 2.5 V input, 1 = processor core supply, 2 = VCC supply, 3 = 5 V input, 4 = 12 V input).
- R6: In lock mode, a select code from 5 to 7 raises no `adc_start`, and all result registers keep their values.
- R7: A write that changes configuration bit 4, configuration bit 6 or select bits 7:5 discards the partial accumulation. After it, a full sixteen fresh samples are needed before the next averaged result.
- R8: Configuration bit 5 is stored and read back at address 0. Writing it neither restarts sequencing nor alters an averaging visit in progress.
- R9: Address 7 returns the `id_pins` levels in bits 4:0 (pin 0 in bit 0) combinationally, with no latching.
- R10: `adc_start` is high for exactly one cycle. Between a cycle with `adc_done` high and the next cycle with `adc_start` high there are exactly GAP_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 configuration, 1 select) |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 3 | Read address (0 configuration, 1 select, 2..6 results, 7 identification pins) |
| rd_data | output | 10 | Combinational read data |
| id_pins | input | 5 | Identification input pins |
| adc_start | output | 1 | One-cycle conversion request |
| adc_chan | output | 3 | Channel number for the request |
| adc_done | input | 1 | Conversion complete pulse |
| adc_sample | input | 10 | Sample valid with `adc_done` |

## Verification
A wrong sample counter or a stale accumulator shows up first in a result register. It changes after fewer than sixteen samples, or it holds a value that is not the floor of the bench's own sum, and this is visible within three cycles of the offending done pulse. A wrong channel pointer shows up as an `adc_start` with an unexpected `adc_chan`, out of the round-robin order or away from the locked channel, on the very next request. A timing-counter fault moves the start pulse off the exact GAP_CYCLES spacing. A missing abort leaves old samples in an averaged result that the bench can tell apart from a fresh sixteen-sample mean.

// File: rtl/vscan_pkg.sv
package vscan_pkg;
    localparam int          NCH       = 5;
    localparam logic [2:0]  LAST_CH   = 3'd4;
    localparam logic [2:0]  A_CFG     = 3'd0;
    localparam logic [2:0]  A_SEL     = 3'd1;
    localparam logic [2:0]  A_RES0    = 3'd2;
    localparam logic [2:0]  A_ID      = 3'd7;
    localparam int          B_NOAVG   = 4;
    localparam int          B_BYPASS  = 5;
    localparam int          B_LOCK    = 6;
    localparam int          SEL_LSB   = 5;

    typedef enum logic {
        SQ_GAP,
        SQ_BUSY
    } sq_state_e;
endpackage

// File: rtl/vscan_regs.sv
module vscan_regs
    import vscan_pkg::*;
#(
    parameter int SAMPLE_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [7:0]          wr_data,
    input  logic [2:0]          rd_addr,
    input  logic [NCH-1:0]      id_pins,
    input  logic                pub_valid,
    input  logic [2:0]          pub_chan,
    input  logic [SAMPLE_W-1:0] pub_value,
    output logic                lock_mode,
    output logic                avg_off,
    output logic [2:0]          sel,
    output logic                restart,
    output logic [SAMPLE_W-1:0] rd_data
);
    typedef struct packed {
        logic                         lock;
        logic                         bypass;
        logic                         noavg;
        logic [2:0]                   sel;
        logic [NCH-1:0][SAMPLE_W-1:0] res;
    } regs_t;

    regs_t q, d;
    logic  unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[3:0], wr_data[7]};

    always_comb begin
        d       = q;
        restart = 1'b0;
        if (wr_en && wr_addr == A_CFG) begin
            d.noavg  = wr_data[B_NOAVG];
            d.bypass = wr_data[B_BYPASS];
            d.lock   = wr_data[B_LOCK];
            restart  = (wr_data[B_NOAVG] != q.noavg) || (wr_data[B_LOCK] != q.lock);
        end
        if (wr_en && wr_addr == A_SEL) begin
            d.sel   = wr_data[SEL_LSB +: 3];
            restart = (wr_data[SEL_LSB +: 3] != q.sel);
        end
        for (int c = 0; c < NCH; c++) begin
            if (pub_valid && pub_chan == 3'(c)) d.res[c] = pub_value;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CFG: begin
                rd_data[B_NOAVG]  = q.noavg;
                rd_data[B_BYPASS] = q.bypass;
                rd_data[B_LOCK]   = q.lock;
            end
            A_SEL:   rd_data[SEL_LSB +: 3] = q.sel;
            A_ID:    rd_data[NCH-1:0]      = id_pins;
            default: begin
                for (int c = 0; c < NCH; c++) begin
                    if (rd_addr == A_RES0 + 3'(c)) rd_data = q.res[c];
                end
            end
        endcase
    end

    assign lock_mode = q.lock;
    assign avg_off   = q.noavg;
    assign sel       = q.sel;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_hold
            assert_hold_unpublished_R6 : assert property (@(posedge clk) disable iff (!rst_n)
                !(pub_valid && pub_chan == 3'(g)) |=> $stable(q.res[g]));
        end
    endgenerate

    assert_bypass_no_restart_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CFG && wr_data[B_NOAVG] == q.noavg && wr_data[B_LOCK] == q.lock)
        |=> ($stable(lock_mode) && $stable(avg_off)));
endmodule

// File: rtl/vscan_seq.sv
module vscan_seq
    import vscan_pkg::*;
#(
    parameter int SAMPLE_W   = 10,
    parameter int AVG_LOG2   = 4,
    parameter int GAP_CYCLES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lock_mode,
    input  logic                avg_off,
    input  logic [2:0]          sel,
    input  logic                restart,
    input  logic                adc_done,
    input  logic [SAMPLE_W-1:0] adc_sample,
    output logic                adc_start,
    output logic [2:0]          adc_chan,
    output logic                pub_valid,
    output logic [2:0]          pub_chan,
    output logic [SAMPLE_W-1:0] pub_value
);
    localparam int ACC_W = SAMPLE_W + AVG_LOG2;
    localparam int GW    = $clog2(GAP_CYCLES + 1);
    localparam logic [GW-1:0]       GAP_LOAD = GW'(GAP_CYCLES - 1);
    localparam logic [AVG_LOG2-1:0] LAST_N   = '1;
    localparam logic [ACC_W-1:0]    ACC_MAX  = ACC_W'((2 ** AVG_LOG2 - 1) * (2 ** SAMPLE_W - 1));

    typedef struct packed {
        sq_state_e           st;
        logic [GW-1:0]       gap;
        logic [2:0]          chan;
        logic [AVG_LOG2-1:0] nsamp;
        logic [ACC_W-1:0]    acc;
        logic                start;
        logic                pub;
        logic [2:0]          pub_chan;
        logic [SAMPLE_W-1:0] pub_val;
    } seq_t;

    seq_t       q, d;
    logic [ACC_W-1:0] sum;
    logic       target_ok;
    logic [2:0] launch_chan;
    logic [2:0] next_chan;

    always_comb begin
        d           = q;
        d.start     = 1'b0;
        d.pub       = 1'b0;
        sum         = q.acc + ACC_W'(adc_sample);
        target_ok   = !lock_mode || (sel <= LAST_CH);
        launch_chan = lock_mode ? sel : q.chan;
        next_chan   = lock_mode ? q.chan : ((q.chan == LAST_CH) ? 3'd0 : q.chan + 3'd1);
        if (restart) begin
            d.st    = SQ_GAP;
            d.gap   = GAP_LOAD;
            d.chan  = 3'd0;
            d.nsamp = '0;
            d.acc   = '0;
        end else begin
            case (q.st)
                SQ_GAP: begin
                    if (q.gap != '0) begin
                        d.gap = q.gap - 1'b1;
                    end else if (target_ok) begin
                        d.st    = SQ_BUSY;
                        d.start = 1'b1;
                        d.chan  = launch_chan;
                    end
                end
                SQ_BUSY: begin
                    if (adc_done) begin
                        d.st  = SQ_GAP;
                        d.gap = GAP_LOAD;
                        if (avg_off) begin
                            d.pub      = 1'b1;
                            d.pub_chan = q.chan;
                            d.pub_val  = adc_sample;
                            d.acc      = '0;
                            d.nsamp    = '0;
                            d.chan     = next_chan;
                        end else if (q.nsamp == LAST_N) begin
                            d.pub      = 1'b1;
                            d.pub_chan = q.chan;
                            d.pub_val  = sum[ACC_W-1:AVG_LOG2];
                            d.acc      = '0;
                            d.nsamp    = '0;
                            d.chan     = next_chan;
                        end else begin
                            d.acc   = sum;
                            d.nsamp = q.nsamp + 1'b1;
                        end
                    end
                end
                default: d.st = SQ_GAP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= SQ_GAP;
            q.gap <= GAP_LOAD;
        end else begin
            q <= d;
        end
    end

    assign adc_start = q.start;
    assign adc_chan  = q.chan;
    assign pub_valid = q.pub;
    assign pub_chan  = q.pub_chan;
    assign pub_value = q.pub_val;

    assert_start_one_cycle_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);
    assert_chan_in_range_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (adc_chan <= LAST_CH));
    assert_locked_chan_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (adc_start && lock_mode) |-> (adc_chan == sel));
    assert_no_start_reserved_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (lock_mode && sel > LAST_CH) |-> !adc_start);
    assert_acc_bound_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        q.acc <= ACC_MAX);
    assert_pub_after_done_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        pub_valid |-> $past(adc_done));
endmodule

// File: rtl/volt_scan_ctrl.sv
module volt_scan_ctrl
    import vscan_pkg::*;
#(
    parameter int SAMPLE_W   = 10,
    parameter int AVG_LOG2   = 4,
    parameter int GAP_CYCLES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [7:0]          wr_data,
    input  logic [2:0]          rd_addr,
    output logic [SAMPLE_W-1:0] rd_data,
    input  logic [NCH-1:0]      id_pins,
    output logic                adc_start,
    output logic [2:0]          adc_chan,
    input  logic                adc_done,
    input  logic [SAMPLE_W-1:0] adc_sample
);
    logic                lock_mode;
    logic                avg_off;
    logic [2:0]          sel;
    logic                restart;
    logic                pub_valid;
    logic [2:0]          pub_chan;
    logic [SAMPLE_W-1:0] pub_value;

    vscan_regs #(.SAMPLE_W(SAMPLE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .id_pins   (id_pins),
        .pub_valid (pub_valid),
        .pub_chan  (pub_chan),
        .pub_value (pub_value),
        .lock_mode (lock_mode),
        .avg_off   (avg_off),
        .sel       (sel),
        .restart   (restart),
        .rd_data   (rd_data)
    );

    vscan_seq #(
        .SAMPLE_W   (SAMPLE_W),
        .AVG_LOG2   (AVG_LOG2),
        .GAP_CYCLES (GAP_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_mode  (lock_mode),
        .avg_off    (avg_off),
        .sel        (sel),
        .restart    (restart),
        .adc_done   (adc_done),
        .adc_sample (adc_sample),
        .adc_start  (adc_start),
        .adc_chan   (adc_chan),
        .pub_valid  (pub_valid),
        .pub_chan   (pub_chan),
        .pub_value  (pub_value)
    );
endmodule

// File: tb/volt_scan_ctrl_test.sv
module volt_scan_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 8;
    localparam int LAT        = 3;
    localparam int NV         = 8;
    localparam logic [12:0] VEC [NV] = '{
        {3'd0, 10'd100}, {3'd1, 10'd1023}, {3'd2, 10'd0}, {3'd3, 10'd517},
        {3'd4, 10'd42},  {3'd0, 10'd1},    {3'd4, 10'd1000}, {3'd2, 10'd333}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [9:0] rd_data;
    logic [4:0] id_pins = '0;
    logic       adc_start;
    logic [2:0] adc_chan;
    logic       adc_done = 1'b0;
    logic [9:0] adc_sample = '0;

    int checks = 0;
    int fails  = 0;
    int ncyc   = 0;
    int done_neg = -100;
    int last_gap = -1;
    int width_err = 0;
    int start_total = 0;
    int tot_conv = 0;
    bit busy = 1'b0;
    bit ramp = 1'b0;
    bit ended = 1'b0;
    logic [9:0] base_val [5];
    int done_cnt [5];
    int start_cnt [5];
    int sum_s [5];
    int chan_log [16];
    logic [9:0] exp_res [5];

    volt_scan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .id_pins(id_pins), .adc_start(adc_start),
        .adc_chan(adc_chan), .adc_done(adc_done), .adc_sample(adc_sample)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) ncyc <= ncyc + 1;

    task automatic check(input string tag, input int got, input int expv);
        checks++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, expv);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    task automatic clear_counts();
        for (int c = 0; c < 5; c++) begin
            done_cnt[c] = 0; start_cnt[c] = 0; sum_s[c] = 0;
        end
        start_total = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [9:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic quiet_write(input logic [2:0] a, input logic [7:0] v, input bit clr);
        @(negedge clk);
        while (adc_start || busy || adc_done) @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        if (clr) clear_counts();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_dones(input int ch, input int n);
        while (done_cnt[ch] < n) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // converter model
    initial begin
        logic [2:0] ch;
        forever begin
            @(negedge clk);
            if (adc_start) begin
                ch = adc_chan;
                busy = 1'b1;
                last_gap = ncyc - done_neg - 1;
                if (start_total < 16) chan_log[start_total] = int'(ch);
                start_total++;
                if (ch < 5) start_cnt[ch]++;
                for (int k = 0; k < LAT; k++) begin
                    @(negedge clk);
                    if (adc_start) width_err++;
                end
                adc_sample = ramp ? (base_val[ch] ^ 10'((tot_conv * 53) % 1024)) : base_val[ch];
                tot_conv++;
                adc_done = 1'b1;
                done_neg = ncyc;
                if (ch < 5) begin
                    done_cnt[ch]++;
                    sum_s[ch] += int'(adc_sample);
                end
                @(negedge clk);
                adc_done = 1'b0;
                busy = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [9:0] v;
        logic [2:0] vs;
        logic [9:0] vv;
        int old;
        for (int c = 0; c < 5; c++) begin
            base_val[c] = 10'(50 + 111 * c);
            exp_res[c] = '0;
        end
        clear_counts();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and quiet start
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            check("R1 reset register", int'(v), 0);
        end
        repeat (GAP - 1) @(negedge clk);
        check("R1 no early start", start_total, 0);

        // R9: identification pins mirrored
        id_pins = 5'b10110;
        rd(3'd7, v);
        check("R9 id pins", int'(v), 22);
        id_pins = 5'b01001;
        rd(3'd7, v);
        check("R9 id pins change", int'(v), 9);

        // R2, R4, R10: round robin without averaging
        quiet_write(3'd0, 8'h10, 1'b1);
        while (start_total < 7) @(negedge clk);
        for (int i = 0; i < 7; i++) check("R2 round-robin order", chan_log[i], i % 5);
        wait_dones(1, 2);
        for (int c = 0; c < 5; c++) begin
            rd(3'(2 + c), v);
            check("R4 unaveraged result", int'(v), int'(base_val[c]));
            exp_res[c] = base_val[c];
        end
        check("R10 gap cycles", last_gap, GAP);
        check("R10 start width", width_err, 0);

        // R5: vector table in lock mode without averaging
        quiet_write(3'd0, 8'h50, 1'b1);
        for (int i = 0; i < NV; i++) begin
            vs = VEC[i][12:10];
            vv = VEC[i][9:0];
            base_val[vs] = vv;
            quiet_write(3'd1, {vs, 5'b0}, 1'b1);
            wait_dones(int'(vs), 2);
            rd(3'(2 + int'(vs)), v);
            check("R5 locked result", int'(v), int'(vv));
            exp_res[vs] = vv;
            check("R5 only locked channel", start_total, start_cnt[vs]);
        end

        // R3, R8: averaging in lock mode, bypass write mid-visit
        ramp = 1'b1;
        quiet_write(3'd1, {3'd2, 5'b0}, 1'b0);
        quiet_write(3'd0, 8'h40, 1'b1);
        wait_dones(2, 8);
        quiet_write(3'd0, 8'h60, 1'b0);
        rd(3'd0, v);
        check("R8 bypass readback", int'(v), 96);
        wait_dones(2, 15);
        rd(3'd4, v);
        check("R3 held before sixteenth", int'(v), int'(exp_res[2]));
        wait_dones(2, 16);
        rd(3'd4, v);
        check("R3 averaged result", int'(v), sum_s[2] / 16);
        exp_res[2] = v;

        // R7: select change aborts partial accumulation
        quiet_write(3'd1, {3'd1, 5'b0}, 1'b1);
        wait_dones(1, 8);
        quiet_write(3'd1, {3'd3, 5'b0}, 1'b1);
        quiet_write(3'd1, {3'd1, 5'b0}, 1'b1);
        wait_dones(1, 15);
        rd(3'd3, v);
        check("R7 partial discarded", int'(v), int'(exp_res[1]));
        wait_dones(1, 16);
        rd(3'd3, v);
        check("R7 fresh average", int'(v), sum_s[1] / 16);
        exp_res[1] = v;

        // R6: reserved select codes
        quiet_write(3'd1, {3'd5, 5'b0}, 1'b1);
        repeat (100) @(negedge clk);
        check("R6 no start code 5", start_total, 0);
        quiet_write(3'd1, {3'd7, 5'b0}, 1'b1);
        repeat (100) @(negedge clk);
        check("R6 no start code 7", start_total, 0);
        for (int c = 0; c < 5; c++) begin
            rd(3'(2 + c), v);
            old = int'(exp_res[c]);
            check("R6 results held", int'(v), old);
        end
        finish_run();
    end
endmodule